// File: doc/BRIEF.md
# Activity Watchdog with Reset Pulse Train

This block supervises another device by watching that device's output data bus. Any cycle in which the bus differs in at least one bit from its value on the previous cycle counts as a sign of life. If no sign of life is seen for a programmable number of clock cycles, the supervised device is taken to be hung.

Once a hang is declared, the block drives a repeating train of reset pulses at the device. Each pulse has a programmable width and is followed by a programmable gap. The train does not stop after one pulse. It ends only when the bus moves during a gap. The block then returns to monitoring and adds one to a saturating count of recoveries. The idle counter is wide enough to cover timeouts of several seconds at the system clock rate.

Top module: `activity_watchdog`

## Requirements
- R1: While `rst_ni` is low, and on the first cycle after it is released, `dev_rst_o` and `hung_o` are 0 and `recov_cnt_o` is 0. The block starts in monitoring with the idle count cleared.
- R2: Activity means that `data_i` differs in any bit from its value sampled on the previous clock edge. In monitoring, activity clears the idle count.
- R3: In monitoring, after `timeout_i` consecutive idle edges (a `timeout_i` of 0 acts as 1), `hung_o` and `dev_rst_o` both rise on the same edge.
- R4: Each reset pulse holds `dev_rst_o` high for `pulse_width_i` cycles. A width of 0 acts as 1.
- R5: Each pulse is followed by `pulse_gap_i` cycles with `dev_rst_o` low (a gap of 0 acts as 1). After that, another pulse starts. This repeats without limit.
- R6: Changes on `data_i` that reach an edge while `dev_rst_o` is high are ignored. The train continues, and such a change does not end the following gap.
- R7: A change on `data_i` seen at an edge during a gap ends the train on that edge. `hung_o` and `dev_rst_o` go low, and monitoring restarts with the idle count cleared.
- R8: `recov_cnt_o` increments by one on each recovery and holds at all ones once it reaches that value.
- R9: `hung_o` stays high from the edge of declaration until the edge of recovery, and `dev_rst_o` is never high while `hung_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | DATA_W | Output data bus of the supervised device |
| timeout_i | input | TO_W | Idle cycles before a hang is declared |
| pulse_width_i | input | PW_W | Reset pulse length in cycles |
| pulse_gap_i | input | PW_W | Low time between pulses in cycles |
| dev_rst_o | output | 1 | Reset pulse to the supervised device, active high |
| hung_o | output | 1 | High while the device is considered hung |
| recov_cnt_o | output | CNT_W | Saturating count of recoveries |

## Verification
A stale previous-bus register or a missed clear of the idle count shows up as `hung_o` rising one or more cycles away from the exact `timeout_i` boundary. The bench samples `hung_o` on the cycle before and the cycle at that boundary. A pulse counter that is not cleared between phases, or that is off by one, bends the high/low pattern of `dev_rst_o` within the first period of the train. A sequencer state that lets activity through during a pulse drops `hung_o` one edge after the change instead of holding it. A recovery counter that wraps shows a smaller value on the first recovery past saturation.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  typedef enum logic [1:0] {
    WD_MON   = 2'd0,
    WD_PULSE = 2'd1,
    WD_GAP   = 2'd2
  } wd_state_e;
endpackage

// File: rtl/wdg_edge_det.sv
module wdg_edge_det #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic              act_o
);
  logic [DATA_W-1:0] prev_q;
  logic [DATA_W-1:0] diff_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= data_i;
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign diff_w[i] = data_i[i] ^ prev_q[i];
  end

  assign act_o = |diff_w;
endmodule

// File: rtl/wdg_idle_timer.sv
module wdg_idle_timer #(
  parameter int TO_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            act_i,
  input  logic [TO_W-1:0] timeout_i,
  output logic            trip_o
);
  logic [TO_W-1:0] idle_q;
  logic [TO_W:0]   idle_nxt;
  logic [TO_W-1:0] thr;

  assign idle_nxt = {1'b0, idle_q} + {{TO_W{1'b0}}, 1'b1};
  assign thr      = (timeout_i == '0) ? {{(TO_W-1){1'b0}}, 1'b1} : timeout_i;
  assign trip_o   = run_i & ~act_i & (idle_nxt >= {1'b0, thr});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         idle_q <= '0;
    else if (!run_i || act_i || trip_o)  idle_q <= '0;
    else                                 idle_q <= idle_nxt[TO_W-1:0];
  end
endmodule

// File: rtl/wdg_pulse_seq.sv
module wdg_pulse_seq
  import wdg_pkg::*;
#(
  parameter int PW_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            trip_i,
  input  logic            act_i,
  input  logic [PW_W-1:0] width_i,
  input  logic [PW_W-1:0] gap_i,
  output wd_state_e       state_o,
  output logic            recover_o
);
  wd_state_e       state_q, state_d;
  logic [PW_W-1:0] cnt_q, cnt_d;
  logic [PW_W-1:0] len, len_eff;
  logic            done;

  assign len     = (state_q == WD_PULSE) ? width_i : gap_i;
  assign len_eff = (len == '0) ? {{(PW_W-1){1'b0}}, 1'b1} : len;
  assign done    = ({1'b0, cnt_q} + {{PW_W{1'b0}}, 1'b1}) >= {1'b0, len_eff};

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q + 1'b1;
    recover_o = 1'b0;
    unique case (state_q)
      WD_MON: begin
        cnt_d = '0;
        if (trip_i) state_d = WD_PULSE;
      end
      WD_PULSE: begin
        // device held in reset: bus changes are not trusted here
        if (done) begin
          state_d = WD_GAP;
          cnt_d   = '0;
        end
      end
      WD_GAP: begin
        if (act_i) begin
          state_d   = WD_MON;
          cnt_d     = '0;
          recover_o = 1'b1;
        end else if (done) begin
          state_d = WD_PULSE;
          cnt_d   = '0;
        end
      end
      default: begin
        state_d = WD_MON;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WD_MON;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/wdg_sat_cnt.sv
module wdg_sat_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (inc_i && !(&cnt_q))  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/activity_watchdog.sv
module activity_watchdog
  import wdg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TO_W   = 32,
  parameter int PW_W   = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic [TO_W-1:0]   timeout_i,
  input  logic [PW_W-1:0]   pulse_width_i,
  input  logic [PW_W-1:0]   pulse_gap_i,
  output logic              dev_rst_o,
  output logic              hung_o,
  output logic [CNT_W-1:0]  recov_cnt_o
);
  logic      act, trip, recover;
  wd_state_e state;

  wdg_edge_det #(.DATA_W(DATA_W)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .data_i(data_i),
    .act_o (act)
  );

  wdg_idle_timer #(.TO_W(TO_W)) u_idle (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (state == WD_MON),
    .act_i    (act),
    .timeout_i(timeout_i),
    .trip_o   (trip)
  );

  wdg_pulse_seq #(.PW_W(PW_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .trip_i   (trip),
    .act_i    (act),
    .width_i  (pulse_width_i),
    .gap_i    (pulse_gap_i),
    .state_o  (state),
    .recover_o(recover)
  );

  wdg_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (recover),
    .cnt_o (recov_cnt_o)
  );

  assign dev_rst_o = (state == WD_PULSE);
  assign hung_o    = (state != WD_MON);
endmodule

// File: rtl/activity_watchdog_chk.sv
module activity_watchdog_chk #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] data_i,
  input logic              dev_rst_o,
  input logic              hung_o,
  input logic [CNT_W-1:0]  recov_cnt_o
);
  logic up_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) up_q <= 1'b0;
    else         up_q <= 1'b1;
  end

  // R9
  pulse_needs_hung_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_rst_o |-> hung_o);

  // R3
  hang_starts_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hung_o) |-> dev_rst_o);

  // R6
  no_exit_from_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hung_o) |-> !$past(dev_rst_o));

  // R7
  exit_counts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hung_o) |-> ((recov_cnt_o == $past(recov_cnt_o) + 1'b1) || (&recov_cnt_o)));

  // R8
  count_monotonic_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recov_cnt_o >= $past(recov_cnt_o));

  // R2
  activity_alive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_q && !hung_o && (data_i != $past(data_i))) |=> !hung_o);
endmodule

bind activity_watchdog activity_watchdog_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .data_i     (data_i),
  .dev_rst_o  (dev_rst_o),
  .hung_o     (hung_o),
  .recov_cnt_o(recov_cnt_o)
);

// File: tb/sim_activity_watchdog.sv
module sim_activity_watchdog;
  localparam int DATA_W = 8;
  localparam int TO_W   = 16;
  localparam int PW_W   = 8;
  localparam int CNT_W  = 2;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [DATA_W-1:0] data_i = '0;
  logic [TO_W-1:0]   timeout_i = 16'd5;
  logic [PW_W-1:0]   pulse_width_i = 8'd20;
  logic [PW_W-1:0]   pulse_gap_i = 8'd20;
  logic              dev_rst_o, hung_o;
  logic [CNT_W-1:0]  recov_cnt_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  activity_watchdog #(.DATA_W(DATA_W), .TO_W(TO_W), .PW_W(PW_W), .CNT_W(CNT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .data_i(data_i), .timeout_i(timeout_i),
    .pulse_width_i(pulse_width_i), .pulse_gap_i(pulse_gap_i),
    .dev_rst_o(dev_rst_o), .hung_o(hung_o), .recov_cnt_o(recov_cnt_o)
  );

  // {timeout, idle edges after kick, bit to toggle, expected hung}
  localparam int VEC [10][4] = '{
    '{5, 4, 0, 0}, '{5, 5, 1, 1}, '{5, 6, 2, 1}, '{1, 0, 3, 0}, '{1, 1, 4, 1},
    '{0, 1, 5, 1}, '{12, 11, 6, 0}, '{12, 12, 7, 1}, '{3, 2, 0, 0}, '{3, 3, 7, 1}
  };

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    data_i = '0;
    step(2);
    rst_ni = 1'b1;
  endtask

  task automatic kick(int b);
    data_i[b] = ~data_i[b];
    step(1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_bad++;
        $display("FAIL watchdog: actual %0d expected 0", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    step(1);
    // R1 reset values
    check("R1 rst dev_rst", int'(dev_rst_o), 0);
    check("R1 rst hung", int'(hung_o), 0);
    check("R1 rst count", int'(recov_cnt_o), 0);
    rst_ni = 1'b1;
    step(1);
    check("R1 first cycle hung", int'(hung_o), 0);

    // R3 / R2 boundary table
    for (int i = 0; i < 10; i++) begin
      do_reset();
      timeout_i = TO_W'(VEC[i][0]);
      pulse_width_i = 8'd20;
      pulse_gap_i = 8'd20;
      kick(VEC[i][2]);
      step(VEC[i][1]);
      check($sformatf("R3 vec%0d hung", i), int'(hung_o), VEC[i][3]);
      check($sformatf("R3 vec%0d dev_rst", i), int'(dev_rst_o), VEC[i][3]);
    end

    // R2: activity on varying bits keeps the device alive, and clears the count mid-way
    do_reset();
    timeout_i = 16'd6;
    for (int k = 0; k < 10; k++) begin
      step(4);
      kick(k % DATA_W);
      check("R2 keepalive hung", int'(hung_o), 0);
    end
    step(4);
    kick(7);
    step(5);
    check("R2 cleared count hung", int'(hung_o), 0);
    step(1);
    check("R2 cleared count hang", int'(hung_o), 1);

    // R4 R5 R9: pulse train shape, width 3, gap 5
    do_reset();
    timeout_i = 16'd4;
    pulse_width_i = 8'd3;
    pulse_gap_i = 8'd5;
    kick(0);
    step(4);
    for (int i = 0; i < 16; i++) begin
      check($sformatf("R4 R5 train pos%0d", i), int'(dev_rst_o), ((i % 8) < 3) ? 1 : 0);
      check("R9 hung held", int'(hung_o), 1);
      step(1);
    end
    // R6: change during a pulse is ignored
    data_i[3] = ~data_i[3];
    step(1);
    check("R6 still pulsing", int'(dev_rst_o), 1);
    step(2);
    check("R6 gap still hung", int'(hung_o), 1);
    check("R6 gap low", int'(dev_rst_o), 0);
    // R7: change in gap ends the train
    data_i[5] = ~data_i[5];
    step(1);
    check("R7 hung cleared", int'(hung_o), 0);
    check("R7 dev_rst low", int'(dev_rst_o), 0);
    check("R8 count one", int'(recov_cnt_o), 1);
    step(3);
    check("R7 idle restart", int'(hung_o), 0);
    step(1);
    check("R7 rehang", int'(hung_o), 1);

    // R8 saturation (CNT_W = 2)
    for (int k = 0; k < 3; k++) begin
      step(3);
      data_i[k] = ~data_i[k];
      step(1);
      check("R8 recovered", int'(hung_o), 0);
      check("R8 count", int'(recov_cnt_o), (k + 2 > 3) ? 3 : k + 2);
      step(4);
      check("R8 rehang", int'(hung_o), 1);
    end

    // R4 R5: zero width and gap act as one
    do_reset();
    timeout_i = 16'd2;
    pulse_width_i = 8'd0;
    pulse_gap_i = 8'd0;
    kick(1);
    step(2);
    for (int i = 0; i < 6; i++) begin
      check("R4 R5 zero len", int'(dev_rst_o), (i % 2 == 0) ? 1 : 0);
      step(1);
    end

    // R1: reset while hung
    rst_ni = 1'b0;
    #1;
    check("R1 async dev_rst", int'(dev_rst_o), 0);
    check("R1 async hung", int'(hung_o), 0);
    check("R1 async count", int'(recov_cnt_o), 0);
    step(1);
    rst_ni = 1'b1;
    step(1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule